// File: doc/BRIEF.md
# Link Rate Negotiation Controller

This controller brings up a point-to-point serial link between two nodes when each node may run at a low rate, a high rate, or both. It drives the transmit-rate and receive-rate selects of a dual-rate transceiver and watches a single "valid data received" indication from the receive path, such as a qualified comma counter. The two ends do not need to share their lowest rate for the link to come up.

A start request latches the node's capability bits. The node then transmits at the fastest rate it supports and hunts over the receive rates it supports, low first. Once one receive rate delivers valid data for long enough, the node moves its transmitter to that same rate and reports lock. If nothing works after a set number of full sweeps, a failed flag is raised and the hunt goes on. After lock, a long enough gap in valid data drops lock and negotiation starts over from the top.

Top module: `link_rate_negotiator`

## Requirements
- R1: A start pulse with at least one capability bit set latches the capabilities, sets tx_rate to the fastest supported rate and rx_rate to the slowest supported rate (rate code 0 = low, 1 = high), and clears locked and failed. A start with both capability bits clear leaves the block idle with both rates at 0, and it never locks while idle.
- R2: Each receive-rate trial lasts DWELL clock cycles. When a trial at the low rate expires and the high rate is supported, rx_rate steps to 1 on the DWELL-th edge after the trial began.
- R3: Unsupported rates are never tried: with only the high rate supported, rx_rate and tx_rate stay 1 while hunting; with only the low rate supported, both stay 0.
- R4: rx_valid held high for PERSIST consecutive cycles inside one trial sets locked on the PERSIST-th edge, copies rx_rate into tx_rate and clears failed. A burst shorter than PERSIST does not lock.
- R5: After MAX_SWEEPS complete sweeps without acceptance, failed is set on the edge that ends the last trial, the sweep count restarts and rx_rate returns to the first supported rate. failed stays set until a lock or a new start.
- R6: While locked, DWELL consecutive cycles with rx_valid low clear locked and restart negotiation as in R1 with the latched capabilities. A gap shorter than DWELL keeps the lock.
- R7: Two nodes wired back to back settle at the high rate when both are dual-rate, at the low rate when either supports only the low rate, and at the high rate when a dual-rate node meets a high-only node.
- R8: After reset the block is idle with tx_rate, rx_rate, locked and failed all 0.
- R9: A start pulse in any state restarts negotiation immediately with the capabilities present at that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart negotiation (one-cycle pulse) |
| cap_lo | input | 1 | Node supports the low rate |
| cap_hi | input | 1 | Node supports the high rate |
| rx_valid | input | 1 | Receive path reports intelligible data this cycle |
| tx_rate | output | 1 | Transmit rate select, 0 = low, 1 = high |
| rx_rate | output | 1 | Receive rate select, 0 = low, 1 = high |
| locked | output | 1 | A common rate has been found and is in use |
| failed | output | 1 | MAX_SWEEPS sweeps ended without success |

## Verification
On every cycle the assertions check that lock always copies the receive rate into the transmit rate, that unsupported rates never appear on the selects, that failed rises only when the sweep limit runs out and lock falls only on a loss timeout or start, and that the trial, persistence and sweep counters stay within range. The exact edges on which a trial expires, a burst is accepted, failed rises and lock drops, together with the rates two back-to-back nodes settle at for each capability pairing, are shown only by the bench scenarios.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } lrn_state_e;

  localparam logic RATE_LO = 1'b0;
  localparam logic RATE_HI = 1'b1;

  // Fastest rate the node can transmit at.
  function automatic logic top_rate(input logic lo, input logic hi);
    return (hi || !lo) ? RATE_HI : RATE_LO;
  endfunction

  // First receive rate of a sweep: low if supported.
  function automatic logic first_rate(input logic lo, input logic hi);
    return (lo || !hi) ? RATE_LO : RATE_HI;
  endfunction

  // True when the given receive rate is the last one of a sweep.
  function automatic logic is_last(input logic rate, input logic hi);
    return (rate == RATE_HI) || !hi;
  endfunction

endpackage

// File: rtl/lrn_trial_timer.sv
module lrn_trial_timer #(
  parameter int DWELL   = 64,
  parameter int PERSIST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic rx_valid,
  output logic accept,
  output logic expire
);
  localparam int TW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int PW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(DWELL - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERSIST - 1);

  logic [TW-1:0] trial_cnt;
  logic [PW-1:0] good_cnt;

  assign accept = run && rx_valid && (good_cnt == P_LAST);
  assign expire = run && !accept && (trial_cnt == T_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial_cnt <= '0;
      good_cnt  <= '0;
    end else if (clear || !run || accept || expire) begin
      trial_cnt <= '0;
      good_cnt  <= '0;
    end else begin
      trial_cnt <= trial_cnt + 1'b1;
      good_cnt  <= rx_valid ? good_cnt + 1'b1 : '0;
    end
  end

  p_trial_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (trial_cnt <= T_LAST))
    else $error("trial counter beyond dwell");

  p_persist_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    good_cnt <= P_LAST)
    else $error("persistence counter beyond limit");

  generate
    if (PERSIST > 1) begin : g_burst
      p_accept_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(rx_valid))
        else $error("acceptance without a preceding valid cycle");
    end
  endgenerate

endmodule

// File: rtl/lrn_sweep_ctr.sv
module lrn_sweep_ctr #(
  parameter int MAX_SWEEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sweep_end,
  output logic give_up
);
  localparam int SW = (MAX_SWEEPS > 1) ? $clog2(MAX_SWEEPS) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(MAX_SWEEPS - 1);

  logic [SW-1:0] sweep_cnt;

  assign give_up = sweep_end && (sweep_cnt == S_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          sweep_cnt <= '0;
    else if (clear)      sweep_cnt <= '0;
    else if (give_up)    sweep_cnt <= '0;
    else if (sweep_end)  sweep_cnt <= sweep_cnt + 1'b1;
  end

  p_sweep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_cnt <= S_LAST)
    else $error("sweep counter beyond limit");

endmodule

// File: rtl/lrn_loss_mon.sv
module lrn_loss_mon #(
  parameter int DWELL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic rx_valid,
  output logic lost
);
  localparam int LW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [LW-1:0] L_LAST = LW'(DWELL - 1);

  logic [LW-1:0] gap_cnt;

  assign lost = armed && !rx_valid && (gap_cnt == L_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                           gap_cnt <= '0;
    else if (!armed || rx_valid || lost)  gap_cnt <= '0;
    else                                  gap_cnt <= gap_cnt + 1'b1;
  end

  p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= L_LAST)
    else $error("gap counter beyond dwell");

  generate
    if (DWELL > 1) begin : g_gap
      p_lost_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !$past(rx_valid))
        else $error("loss declared after a valid cycle");
    end
  endgenerate

endmodule

// File: rtl/link_rate_negotiator.sv
module link_rate_negotiator #(
  parameter int DWELL      = 64,
  parameter int PERSIST    = 8,
  parameter int MAX_SWEEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cap_lo,
  input  logic cap_hi,
  input  logic rx_valid,
  output logic tx_rate,
  output logic rx_rate,
  output logic locked,
  output logic failed
);
  import lrn_pkg::*;

  lrn_state_e st;
  logic cap_lo_q, cap_hi_q;
  logic tx_q, rx_q, failed_q;

  // Named internal events
  logic hunting, accept, expire, last_rate, sweep_end, give_up, lost, any_cap;

  assign hunting   = (st == ST_HUNT);
  assign any_cap   = cap_lo | cap_hi;
  assign last_rate = is_last(rx_q, cap_hi_q);
  assign sweep_end = expire && last_rate;

  lrn_trial_timer #(.DWELL(DWELL), .PERSIST(PERSIST)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (hunting),
    .clear    (start),
    .rx_valid (rx_valid),
    .accept   (accept),
    .expire   (expire)
  );

  lrn_sweep_ctr #(.MAX_SWEEPS(MAX_SWEEPS)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start || !hunting),
    .sweep_end (sweep_end),
    .give_up   (give_up)
  );

  lrn_loss_mon #(.DWELL(DWELL)) u_loss (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (st == ST_LOCK),
    .rx_valid (rx_valid),
    .lost     (lost)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cap_lo_q <= 1'b0;
      cap_hi_q <= 1'b0;
      tx_q     <= RATE_LO;
      rx_q     <= RATE_LO;
      failed_q <= 1'b0;
    end else if (start) begin
      cap_lo_q <= cap_lo;
      cap_hi_q <= cap_hi;
      failed_q <= 1'b0;
      if (any_cap) begin
        st   <= ST_HUNT;
        tx_q <= top_rate(cap_lo, cap_hi);
        rx_q <= first_rate(cap_lo, cap_hi);
      end else begin
        st   <= ST_IDLE;
        tx_q <= RATE_LO;
        rx_q <= RATE_LO;
      end
    end else begin
      unique case (st)
        ST_HUNT: begin
          if (accept) begin
            st       <= ST_LOCK;
            tx_q     <= rx_q;
            failed_q <= 1'b0;
          end else if (expire) begin
            if (last_rate) begin
              rx_q <= first_rate(cap_lo_q, cap_hi_q);
              if (give_up) failed_q <= 1'b1;
            end else begin
              rx_q <= RATE_HI;
            end
          end
        end
        ST_LOCK: begin
          if (lost) begin
            st   <= ST_HUNT;
            tx_q <= top_rate(cap_lo_q, cap_hi_q);
            rx_q <= first_rate(cap_lo_q, cap_hi_q);
          end
        end
        default: ;
      endcase
    end
  end

  assign tx_rate = tx_q;
  assign rx_rate = rx_q;
  assign locked  = (st == ST_LOCK);
  assign failed  = failed_q;

  p_start_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(any_cap)) |->
      (tx_rate == top_rate($past(cap_lo), $past(cap_hi)) && !locked && !failed))
    else $error("start did not pick the fastest transmit rate");

  p_lock_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (tx_rate == $past(rx_rate)))
    else $error("lock did not copy receive rate to transmit");

  p_skip_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !cap_lo_q) |-> (rx_rate == RATE_HI && tx_rate == RATE_HI))
    else $error("unsupported low rate selected");

  p_skip_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !cap_hi_q) |-> (rx_rate == RATE_LO && tx_rate == RATE_LO))
    else $error("unsupported high rate selected");

  p_fail_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed) |-> $past(give_up))
    else $error("failed rose without sweep limit");

  p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(lost) || $past(start)))
    else $error("lock dropped without loss timeout or start");

endmodule

// File: tb/tb_link_rate_negotiator.sv
module tb_link_rate_negotiator;
  localparam int DW = 8;
  localparam int PS = 3;
  localparam int MS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_start = 1'b0, a_lo = 1'b0, a_hi = 1'b0, drv_valid = 1'b0;
  logic b_start = 1'b0, b_lo = 1'b0, b_hi = 1'b0;
  logic peer_mode = 1'b0, a_on = 1'b0, b_on = 1'b0;
  logic a_tx, a_rx, a_lock, a_fail;
  logic b_tx, b_rx, b_lock, b_fail;
  logic a_valid, b_valid;

  int n_tests = 0;
  int n_fail = 0;
  logic [1:0] exp_q[$];
  logic lock_prev = 1'b0;

  always #4 clk = ~clk;

  assign a_valid = peer_mode ? (b_on && a_rx == b_tx) : drv_valid;
  assign b_valid = a_on && (b_rx == a_tx);

  link_rate_negotiator #(.DWELL(DW), .PERSIST(PS), .MAX_SWEEPS(MS)) dut (
    .clk(clk), .rst_n(rst_n), .start(a_start), .cap_lo(a_lo), .cap_hi(a_hi),
    .rx_valid(a_valid), .tx_rate(a_tx), .rx_rate(a_rx), .locked(a_lock), .failed(a_fail));

  link_rate_negotiator #(.DWELL(DW), .PERSIST(PS), .MAX_SWEEPS(MS)) peer (
    .clk(clk), .rst_n(rst_n), .start(b_start), .cap_lo(b_lo), .cap_hi(b_hi),
    .rx_valid(b_valid), .tx_rate(b_tx), .rx_rate(b_rx), .locked(b_lock), .failed(b_fail));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver side of the scoreboard: expected {tx,rx} at the next lock.
  task automatic expect_lock(input logic tx, input logic rx);
    exp_q.push_back({tx, rx});
  endtask

  // Monitor: on each rising lock, pop and compare.
  always @(posedge clk) begin
    #2;
    if (a_lock && !lock_prev) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected lock actual=%0h expected=none", {a_tx, a_rx});
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if ({a_tx, a_rx} !== e) begin
          n_fail++;
          $display("FAIL R7 lock rates actual=%0h expected=%0h", {a_tx, a_rx}, e);
        end
      end
    end
    lock_prev = a_lock;
  end

  task automatic do_reset();
    rst_n = 1'b0; peer_mode = 1'b0; a_on = 1'b0; b_on = 1'b0;
    drv_valid = 1'b0; a_start = 1'b0; b_start = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_a(input logic lo, input logic hi);
    a_lo = lo; a_hi = hi; a_start = 1'b1;
    tick(1);
    a_start = 1'b0;
  endtask

  task automatic pair_run(input logic alo, input logic ahi, input logic blo, input logic bhi,
                          input logic erate, input string tag);
    do_reset();
    peer_mode = 1'b1;
    expect_lock(erate, erate);
    a_lo = alo; a_hi = ahi; b_lo = blo; b_hi = bhi;
    a_start = 1'b1; b_start = 1'b1; a_on = 1'b1; b_on = 1'b1;
    tick(1);
    a_start = 1'b0; b_start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (a_lock && b_lock) break;
      tick(1);
    end
    tick(2);
    chk({tag, " both locked"}, {30'd0, a_lock, b_lock}, 32'd3);
    chk({tag, " peer rates"}, {30'd0, b_tx, b_rx}, {30'd0, erate, erate});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    chk("R8 reset outputs", {28'd0, a_tx, a_rx, a_lock, a_fail}, 32'd0);

    // R1 dual-rate start
    pulse_a(1'b1, 1'b1);
    chk("R1 start tx/rx", {30'd0, a_tx, a_rx}, 32'b10);
    // R2 trial length
    tick(DW - 1);
    chk("R2 rx before dwell end", {31'd0, a_rx}, 32'd0);
    tick(1);
    chk("R2 rx steps to high", {31'd0, a_rx}, 32'd1);
    tick(DW);
    chk("R2 sweep wraps to low", {31'd0, a_rx}, 32'd0);
    tick(DW);
    chk("R5 not failed after one sweep", {31'd0, a_fail}, 32'd0);
    tick(DW - 1);
    chk("R5 failed not yet", {31'd0, a_fail}, 32'd0);
    tick(1);
    chk("R5 failed after sweep limit", {30'd0, a_fail, a_rx}, 32'b10);

    // R4 short burst does not lock
    drv_valid = 1'b1;
    tick(PS - 1);
    drv_valid = 1'b0;
    tick(1);
    chk("R4 short burst no lock", {31'd0, a_lock}, 32'd0);
    // R4 full burst locks
    expect_lock(1'b0, 1'b0);
    drv_valid = 1'b1;
    tick(PS - 1);
    chk("R4 lock not before persist", {31'd0, a_lock}, 32'd0);
    tick(1);
    chk("R4 lock copies rate, clears failed", {29'd0, a_lock, a_tx, a_fail}, 32'b100);

    // R6 short gaps keep lock
    drv_valid = 1'b0;
    tick(DW - 1);
    chk("R6 short gap keeps lock", {31'd0, a_lock}, 32'd1);
    drv_valid = 1'b1;
    tick(1);
    drv_valid = 1'b0;
    tick(DW - 1);
    chk("R6 second short gap keeps lock", {31'd0, a_lock}, 32'd1);
    tick(1);
    chk("R6 loss restarts at top rate", {29'd0, a_lock, a_tx, a_rx}, 32'b010);

    // R9 + R3 restart with high-only while hunting
    pulse_a(1'b0, 1'b1);
    chk("R9 restart high-only", {30'd0, a_tx, a_rx}, 32'b11);
    tick(DW);
    chk("R3 low rate skipped", {30'd0, a_tx, a_rx}, 32'b11);

    // R1 no capability: idle, never locks
    pulse_a(1'b0, 1'b0);
    chk("R1 no-cap idle rates", {29'd0, a_tx, a_rx, a_lock}, 32'd0);
    drv_valid = 1'b1;
    tick(3 * DW);
    chk("R1 idle never locks", {31'd0, a_lock}, 32'd0);
    drv_valid = 1'b0;

    // R3 low-only
    pulse_a(1'b1, 1'b0);
    chk("R3 low-only start", {30'd0, a_tx, a_rx}, 32'b00);
    tick(DW);
    chk("R3 high rate skipped", {30'd0, a_tx, a_rx}, 32'b00);

    // R7 pairings
    pair_run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7 dual-dual");
    pair_run(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 dual-low");
    pair_run(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 dual-high");
    pair_run(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 low-dual");

    tick(2);
    chk("R7 scoreboard drained", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule